// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. After reset it walks the memory device from power-on to an idle state that is ready for normal traffic. It drives the clock enable, the four low-true command strobes (chip select, row strobe, column strobe, write enable), the bank address and the address bus, one command per clock. Every pause between commands is counted out in clock cycles, and each pause length is a parameter. The parameters cover the clock-stable delay, the precharge recovery, the mode-register recovery, the refresh recovery and the DLL lock time.

The steps run in a fixed order:

1. Clock enable rises while no-operation commands are held for the stable-clock delay.
2. All banks are precharged.
3. The extended mode register is written to enable the DLL.
4. The mode register is written with the DLL reset bit set.
5. All banks are precharged again.
6. A parameterized number of auto-refresh commands is issued, with at least two.
7. The mode register is written once more with the DLL reset bit cleared.

After the last recovery time, `init_done` rises and stays high. A separate `read_allowed` flag stays low until the initialization has finished and the DLL lock count, measured from the DLL-reset command, has expired. The controller that follows uses it to gate its first read.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` is 0, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1 (deselect), and `init_done` and `read_allowed` are 0.
- R2: After reset is released, `cke` rises and stays high. No-operation commands are driven ({cs_n,ras_n,cas_n,we_n} = 0111) until the first real command, which appears exactly T_STABLE cycles after the cycle in which `cke` first reads high.
- R3: The commands appear in this order: precharge-all, extended mode set, mode set with DLL reset, precharge-all, the refresh commands, final mode set. The codes for {cs_n,ras_n,cas_n,we_n} are: precharge 0010, refresh 0001, mode set 0000.
- R4: A precharge drives address bit 10 high and all other address bits to 0, with `ba` = 0. A refresh drives `ba` and `addr` to 0.
- R5: The extended mode set drives `ba` = 01, address bit 0 low (DLL enabled), address bit 1 = EMR_DS (drive strength), and all other address bits 0.
- R6: Each mode set drives `ba` = 00, with burst length code MR_BL on address bits 2..0, burst type MR_BT on bit 3 and latency code MR_CL on bits 6..4. Address bit 8 is 1 on the first mode set (DLL reset) and 0 on the final one. All other address bits are 0.
- R7: The next command follows exactly T_RP cycles after each precharge, T_MRD cycles after each mode or extended mode set, and T_RFC cycles after each refresh. Any value below 2 acts as 2.
- R8: `init_done` rises exactly T_MRD cycles after the final mode set and then stays high. From then on only no-operation commands are driven.
- R9: `read_allowed` rises in the first cycle that is both at or after T_DLL cycles past the DLL-reset mode set and one in which `init_done` is high. It stays low before that cycle.
- R10: Exactly N_REF refresh commands are issued. Any value below 2 acts as 2.
- R11: Asserting `rst_n` in the middle of the sequence returns the outputs to the R1 state at once. After release, the whole sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, low-true |
| ras_n | output | 1 | Row strobe, low-true |
| cas_n | output | 1 | Column strobe, low-true |
| we_n | output | 1 | Write enable, low-true |
| ba | output | BA_W | Bank address, selects the extended register on mode sets |
| addr | output | ADDR_W | Address bus carrying mode-register values |
| init_done | output | 1 | High once initialization is complete |
| read_allowed | output | 1 | High once reads are permitted after DLL lock |

## Verification
A wrong step value in the sequencer shows up at the command pins on the very next clock, as a command out of order, with the wrong bank or address, or where a no-operation should be. A scoreboard that stamps every command with its cycle catches it at once. A gap counter that is off by even one cycle moves the next command stamp, so the gap comparison reports it at that command. An error in the DLL lock counter changes the cycle in which `read_allowed` rises, and it is found by comparing that cycle with the stamp of the DLL-reset command.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    STP_RESET,
    STP_CKE,
    STP_PRE_A,
    STP_EMR,
    STP_MR_DLL,
    STP_PRE_B,
    STP_REF,
    STP_MR_RUN,
    STP_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_MRS   = 4'b0000;

  function automatic int at_least_two(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_rst_sync.sv
module ddr_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int T_STABLE = 20,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 14,
  parameter int N_REF    = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  output step_e step_o,
  output logic  issue_o
);
  localparam int G_STABLE = at_least_two(T_STABLE);
  localparam int G_RP     = at_least_two(T_RP);
  localparam int G_MRD    = at_least_two(T_MRD);
  localparam int G_RFC    = at_least_two(T_RFC);
  localparam int G_MAX    = max_of(max_of(G_STABLE, G_RP), max_of(G_MRD, G_RFC));
  localparam int CNT_W    = $clog2(G_MAX + 1);
  localparam int REF_N    = at_least_two(N_REF);
  localparam int REF_W    = $clog2(REF_N + 1);

  step_e            step_q, step_d;
  logic             wait_q, wait_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [CNT_W-1:0] gap_m1;
  logic             adv_en;

  // gap minus one for the command issued in this step
  always_comb begin
    case (step_q)
      STP_CKE:    gap_m1 = CNT_W'(G_STABLE - 1);
      STP_PRE_A,
      STP_PRE_B:  gap_m1 = CNT_W'(G_RP - 1);
      STP_EMR,
      STP_MR_DLL,
      STP_MR_RUN: gap_m1 = CNT_W'(G_MRD - 1);
      STP_REF:    gap_m1 = CNT_W'(G_RFC - 1);
      default:    gap_m1 = '0;
    endcase
  end

  // next-state process
  always_comb begin
    step_d = step_q;
    wait_d = wait_q;
    cnt_d  = cnt_q;
    ref_d  = ref_q;
    adv_en = 1'b1;
    if (step_q == STP_RESET) begin
      step_d = STP_CKE;
      wait_d = 1'b0;
    end else if (step_q == STP_DONE) begin
      adv_en = 1'b0;
    end else if (!wait_q) begin
      wait_d = 1'b1;
      cnt_d  = gap_m1;
    end else if (cnt_q == CNT_W'(1)) begin
      wait_d = 1'b0;
      case (step_q)
        STP_CKE:    step_d = STP_PRE_A;
        STP_PRE_A:  step_d = STP_EMR;
        STP_EMR:    step_d = STP_MR_DLL;
        STP_MR_DLL: step_d = STP_PRE_B;
        STP_PRE_B: begin
          step_d = STP_REF;
          ref_d  = '0;
        end
        STP_REF: begin
          ref_d  = ref_q + REF_W'(1);
          step_d = (ref_q == REF_W'(REF_N - 1)) ? STP_MR_RUN : STP_REF;
        end
        STP_MR_RUN: step_d = STP_DONE;
        default:    step_d = STP_DONE;
      endcase
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STP_RESET;
      wait_q <= 1'b0;
      cnt_q  <= '0;
      ref_q  <= '0;
    end else if (adv_en) begin
      step_q <= step_d;
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
      ref_q  <= ref_d;
    end
  end

  assign step_o  = step_q;
  assign issue_o = !wait_q && (step_q != STP_RESET) && (step_q != STP_DONE);
endmodule

// File: rtl/ddr_init_dll_timer.sv
module ddr_init_dll_timer #(
  parameter int T_DLL = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expired_o
);
  localparam int LOCK  = (T_DLL < 1) ? 1 : T_DLL;
  localparam int CNT_W = $clog2(LOCK + 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start_i) begin
      armed_d = 1'b1;
      cnt_d   = CNT_W'(LOCK - 1);
      cnt_en  = 1'b1;
    end else if (armed_q && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W = 13,
  parameter int          BA_W   = 2,
  parameter logic [2:0]  MR_BL  = 3'b010,
  parameter logic        MR_BT  = 1'b0,
  parameter logic [2:0]  MR_CL  = 3'b010,
  parameter logic        EMR_DS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             step_i,
  input  logic              issue_i,
  input  logic              dll_expired_i,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              rd_ok_o
);
  localparam int AP_BIT  = 10;
  localparam int DLL_BIT = 8;

  function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
    logic [ADDR_W-1:0] w;
    w          = '0;
    w[2:0]     = MR_BL;
    w[3]       = MR_BT;
    w[6:4]     = MR_CL;
    w[DLL_BIT] = dll_rst;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] ext_word();
    logic [ADDR_W-1:0] w;
    w    = '0;
    w[0] = 1'b0;
    w[1] = EMR_DS;
    return w;
  endfunction

  logic              cke_d;
  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              done_d, rd_ok_d;

  always_comb begin
    cke_d   = 1'b1;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    done_d  = (step_i == STP_DONE);
    rd_ok_d = (step_i == STP_DONE) && dll_expired_i;
    if (step_i == STP_RESET) begin
      cke_d = 1'b0;
      cmd_d = CMD_DESEL;
    end else if (issue_i) begin
      case (step_i)
        STP_PRE_A, STP_PRE_B: begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
        end
        STP_EMR: begin
          cmd_d  = CMD_MRS;
          ba_d   = BA_W'(1);
          addr_d = ext_word();
        end
        STP_MR_DLL: begin
          cmd_d  = CMD_MRS;
          addr_d = mode_word(1'b1);
        end
        STP_MR_RUN: begin
          cmd_d  = CMD_MRS;
          addr_d = mode_word(1'b0);
        end
        STP_REF:  cmd_d = CMD_REF;
        default:  cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_o   <= 1'b0;
      cmd_o   <= CMD_DESEL;
      ba_o    <= '0;
      addr_o  <= '0;
      done_o  <= 1'b0;
      rd_ok_o <= 1'b0;
    end else begin
      cke_o   <= cke_d;
      cmd_o   <= cmd_d;
      ba_o    <= ba_d;
      addr_o  <= addr_d;
      done_o  <= done_d;
      rd_ok_o <= rd_ok_d;
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter int          BA_W     = 2,
  parameter int          T_STABLE = 20,
  parameter int          T_RP     = 3,
  parameter int          T_MRD    = 2,
  parameter int          T_RFC    = 14,
  parameter int          T_DLL    = 200,
  parameter int          N_REF    = 2,
  parameter logic [2:0]  MR_BL    = 3'b010,
  parameter logic        MR_BT    = 1'b0,
  parameter logic [2:0]  MR_CL    = 3'b010,
  parameter logic        EMR_DS   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              read_allowed
);
  logic       rst_sync_n;
  step_e      step;
  logic       issue;
  logic       dll_start;
  logic       dll_expired;
  logic [3:0] cmd;

  ddr_init_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddr_init_fsm #(
    .T_STABLE (T_STABLE),
    .T_RP     (T_RP),
    .T_MRD    (T_MRD),
    .T_RFC    (T_RFC),
    .N_REF    (N_REF)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_o  (step),
    .issue_o (issue)
  );

  assign dll_start = issue && (step == STP_MR_DLL);

  ddr_init_dll_timer #(.T_DLL(T_DLL)) u_dll (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (dll_start),
    .expired_o (dll_expired)
  );

  ddr_init_cmd_enc #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .MR_BL  (MR_BL),
    .MR_BT  (MR_BT),
    .MR_CL  (MR_CL),
    .EMR_DS (EMR_DS)
  ) u_enc (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step),
    .issue_i       (issue),
    .dll_expired_i (dll_expired),
    .cke_o         (cke),
    .cmd_o         (cmd),
    .ba_o          (ba),
    .addr_o        (addr),
    .done_o        (init_done),
    .rd_ok_o       (read_allowed)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              read_allowed
);
  logic [3:0] code;
  assign code = {cs_n, ras_n, cas_n, we_n};

  // R1
  a_r1_reset_outputs: assert property (@(posedge clk)
    !rst_n |-> (!cke && cs_n && !init_done && !read_allowed));

  // R2
  a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R4
  a_r4_precharge_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && code == 4'b0010) |-> addr[10]);

  // R5 / R6
  a_r6_mode_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && code == 4'b0000) |-> (ba[BA_W-1:1] == '0));

  // R8
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (code == 4'b0111));

  // R9
  a_r9_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    read_allowed |-> init_done);
endmodule

bind ddr_init_seq ddr_init_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cke          (cke),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .ba           (ba),
  .addr         (addr),
  .init_done    (init_done),
  .read_allowed (read_allowed)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;
  localparam int         ADDR_W   = 13;
  localparam int         BA_W     = 2;
  localparam int         T_STABLE = 10;
  localparam int         T_RP     = 3;
  localparam int         T_MRD    = 2;
  localparam int         T_RFC    = 7;
  localparam int         T_DLL    = 40;
  localparam int         N_REF    = 3;
  localparam logic [2:0] MR_BL    = 3'b011;
  localparam logic       MR_BT    = 1'b1;
  localparam logic [2:0] MR_CL    = 3'b101;
  localparam logic       EMR_DS   = 1'b1;

  typedef struct packed {
    logic [3:0]        code;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       gap;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, read_allowed;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;

  always #2.5 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_STABLE(T_STABLE), .T_RP(T_RP),
    .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLL(T_DLL), .N_REF(N_REF),
    .MR_BL(MR_BL), .MR_BT(MR_BT), .MR_CL(MR_CL), .EMR_DS(EMR_DS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .read_allowed(read_allowed)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  exp_t exp_q[$];
  bit   mon_en = 1'b0;
  int   cyc, last_stamp, dll_stamp, final_stamp, seen;
  bit   cke_seen, dll_seen, final_seen;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [3:0] c, input logic [BA_W-1:0] b,
                          input logic [ADDR_W-1:0] a, input int g);
    exp_t e;
    e.code = c; e.ba = b; e.addr = a; e.gap = 32'(g);
    exp_q.push_back(e);
  endtask

  // driver: expected sequence from the requirements (R3..R7, R10)
  task automatic push_sequence();
    logic [ADDR_W-1:0] mr;
    logic [ADDR_W-1:0] mr_dll;
    mr = '0;
    mr[2:0] = MR_BL; mr[3] = MR_BT; mr[6:4] = MR_CL;
    mr_dll = mr; mr_dll[8] = 1'b1;
    push_cmd(4'b0010, 2'b00, 13'h400, T_STABLE);        // R2 R4 precharge-all
    push_cmd(4'b0000, 2'b01, {12'h0, EMR_DS, 1'b0}, T_RP); // R5 extended set
    push_cmd(4'b0000, 2'b00, mr_dll, T_MRD);             // R6 DLL reset
    push_cmd(4'b0010, 2'b00, 13'h400, T_MRD);            // R4 precharge-all
    push_cmd(4'b0001, 2'b00, '0, T_RP);                  // R10 first refresh
    for (int i = 1; i < N_REF; i++)
      push_cmd(4'b0001, 2'b00, '0, T_RFC);               // R7 R10
    push_cmd(4'b0000, 2'b00, mr, T_RFC);                 // R6 final set
  endtask

  task automatic clear_monitor();
    cyc = 0; last_stamp = 0; dll_stamp = 0; final_stamp = 0; seen = 0;
    cke_seen = 0; dll_seen = 0; final_seen = 0;
  endtask

  // monitor: sample away from the rising edge
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      logic [3:0] code;
      bit init_exp, rd_exp;
      cyc++;
      code = {cs_n, ras_n, cas_n, we_n};
      if (!cke_seen) begin
        if (cke) begin
          cke_seen   = 1;
          last_stamp = cyc;
          check(code == 4'b0111, "R2 nop on cke rise", code, 4'b0111);
        end else begin
          check(cs_n == 1'b1, "R1 deselect before cke", cs_n, 1);
        end
      end else begin
        check(cke == 1'b1, "R2 cke stays high", cke, 1);
        if (code != 4'b0111) begin
          if (exp_q.size() == 0) begin
            check(0, "R3 unexpected command", code, 4'b0111);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            seen++;
            check(code == e.code, "R3 command order", code, e.code);
            check(ba == e.ba, "R5 R6 bank", ba, e.ba);
            check(addr == e.addr, "R4 R5 R6 address", addr, e.addr);
            check(32'(cyc - last_stamp) == e.gap, "R7 command gap", cyc - last_stamp, e.gap);
            last_stamp = cyc;
            if (code == 4'b0000 && ba == '0 && addr[8]) begin
              dll_seen = 1; dll_stamp = cyc;
            end
            if (code == 4'b0000 && ba == '0 && !addr[8]) begin
              final_seen = 1; final_stamp = cyc;
            end
          end
        end
        init_exp = final_seen && (cyc - final_stamp >= T_MRD);
        rd_exp   = init_exp && dll_seen && (cyc - dll_stamp >= T_DLL);
        check(init_done == init_exp, "R8 init_done timing", init_done, init_exp);
        check(read_allowed == rd_exp, "R9 read_allowed timing", read_allowed, rd_exp);
      end
    end
  end

  task automatic check_reset_state(input string tag);
    check(cke == 1'b0, {tag, " cke low"}, cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b1111, {tag, " deselect"},
          {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    check(init_done == 1'b0, {tag, " init_done low"}, init_done, 0);
    check(read_allowed == 1'b0, {tag, " read_allowed low"}, read_allowed, 0);
  endtask

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 check_reset_state("R1");

    // full run
    clear_monitor();
    push_sequence();
    mon_en = 1'b1;
    rst_n  = 1'b1;
    wait (final_seen);
    repeat (T_DLL + 10) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R3 R10 all commands issued", exp_q.size(), 0);
    check(seen == N_REF + 5, "R10 command count", seen, N_REF + 5);
    check(init_done == 1'b1, "R8 init_done final", init_done, 1);
    check(read_allowed == 1'b1, "R9 read_allowed final", read_allowed, 1);

    // mid-sequence reset
    @(posedge clk); #1;
    clear_monitor();
    exp_q.delete();
    rst_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    push_sequence();
    rst_n = 1'b1;
    wait (seen == 3);
    @(posedge clk); #1;
    mon_en = 1'b0;
    rst_n  = 1'b0;
    #1 check_reset_state("R11");
    exp_q.delete();
    repeat (3) @(posedge clk); #1;
    clear_monitor();
    push_sequence();
    mon_en = 1'b1;
    rst_n  = 1'b1;
    wait (final_seen);
    repeat (T_DLL + 10) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R11 restart completes", exp_q.size(), 0);
    check(read_allowed == 1'b1, "R11 R9 read_allowed after restart", read_allowed, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", seen, N_REF + 5);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule